// File: doc/BRIEF.md
# Cascadable Eight-Request Priority Encoder

This block turns a vector of request lines into the binary index of the most important one that is asserted. Request 7 outranks request 6, which outranks 5, and so on down to request 0. Each active request, when a higher-ranked one is also active, has no influence on the result. Every pin is active-low. A low enable input arms the unit. A group-valid output goes low whenever the armed unit sees any request. An idle-pass output goes low only when the unit is armed and sees none.

The idle-pass output is meant to drive the enable input of the next, lower-ranked unit. A chain of units therefore encodes a wider request vector, and an upper unit that has work silences everything below it. The top module wires two units into a sixteen-request encoder. The upper unit's group-valid output becomes the most significant code bit. The two lower three-bit codes are merged with an AND, because a silenced unit drives all ones.

The encoder has no storage. The index comes from "top hit" terms: each term marks one request that is active while every request above it is idle. Each code bit is then the OR of the top-hit terms whose index has that bit set. A plain OR of the raw requests would merge indices; for example, requests 2 and 4 together would give 6.

Top module: `prio_enc_cascade`

## Requirements
- R1: An armed unit (enable low) with at least one active request drives code_n as the bitwise inverse of the index of the highest active request. Code bit b is low exactly when bit b of that index is 1, and bit 0 is the least significant.
- R2: In a unit, active requests below the highest active one have no effect on the code. With requests 2 and 4 active, the code reports index 4, not 6.
- R3: A unit's group-valid output is low exactly when the unit is armed and at least one request is low.
- R4: A unit's idle-pass output is low exactly when the unit is armed and every request is high. In that case the unit's code is all ones.
- R5: A unit whose enable is high drives its code, group-valid and idle-pass outputs all high, whatever its requests.
- R6: When armed with at least one active request, the cascade drives its 4-bit code_n as the inverse of the index (0 to 15) of the highest active request. When armed with no active request, code_n is all ones.
- R7: In the cascade, while any of requests 8 to 15 is active, requests 0 to 7 have no effect on any output.
- R8: The cascade's gs_n is low exactly when it is armed and any of the 16 requests is low. Its eout_n is low exactly when it is armed and all 16 requests are high. The two are never low together.
- R9: With ein_n high, the cascade drives code_n, gs_n and eout_n all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_n | input | 16 | Request lines, active-low; bit 15 has the highest rank |
| ein_n | input | 1 | Enable for the whole cascade, active-low |
| code_n | output | 4 | Index of the winning request, inverted |
| gs_n | output | 1 | Low when armed and any request is active |
| eout_n | output | 1 | Low when armed and no request is active; feeds a further lower unit |

## Verification
Every output is a pure function of the current inputs, so each result is due in the same cycle its stimulus is applied, after combinational settling. The driver applies a pattern on the falling clock edge and queues the expected values. The monitor compares shortly after the next rising edge, half a period later. Patterns change only on falling edges, so each comparison sees a settled response to exactly one queued stimulus.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  localparam int unsigned DEF_UNIT_REQS = 8;
endpackage

// File: rtl/pe_top_find.sv
module pe_top_find #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] top_hot
);
  // term i is set only when request i is active and all higher ones are idle
  for (genvar i = 0; i < N; i++) begin : g_hot
    if (i == N - 1) begin : g_msb
      assign top_hot[i] = req[i];
    end else begin : g_rest
      assign top_hot[i] = req[i] & ~(|req[N-1:i+1]);
    end
  end
endmodule

// File: rtl/pe_code_or.sv
module pe_code_or #(
  parameter int unsigned N  = 8,
  parameter int unsigned CW = $clog2(N)
) (
  input  logic [N-1:0]  top_hot,
  output logic [CW-1:0] code
);
  logic [CW-1:0][N-1:0] sel;

  for (genvar b = 0; b < CW; b++) begin : g_bit
    for (genvar i = 0; i < N; i++) begin : g_term
      assign sel[b][i] = (((i >> b) & 1) == 1) ? top_hot[i] : 1'b0;
    end
    assign code[b] = |sel[b];
  end
endmodule

// File: rtl/prio_enc_unit.sv
module prio_enc_unit #(
  parameter int unsigned N = prio_enc_pkg::DEF_UNIT_REQS,
  localparam int unsigned CW = $clog2(N)
) (
  input  logic [N-1:0]  req_n,
  input  logic          ein_n,
  output logic [CW-1:0] code_n,
  output logic          gs_n,
  output logic          eout_n
);
  logic [N-1:0]  req;
  logic [N-1:0]  top_hot;
  logic [CW-1:0] code;
  logic          armed;
  logic          any_req;

  assign req     = ~req_n;
  assign armed   = ~ein_n;
  assign any_req = |req;

  pe_top_find #(.N(N)) u_find (
    .req     (req),
    .top_hot (top_hot)
  );

  pe_code_or #(.N(N), .CW(CW)) u_code (
    .top_hot (top_hot),
    .code    (code)
  );

  always_comb begin
    code_n = '1;
    gs_n   = 1'b1;
    eout_n = 1'b1;
    if (armed) begin
      if (any_req) begin
        code_n = ~code;
        gs_n   = 1'b0;
      end else begin
        eout_n = 1'b0;
      end
    end
  end
endmodule

// File: rtl/prio_enc_cascade.sv
module prio_enc_cascade #(
  parameter int unsigned UNIT_REQS = prio_enc_pkg::DEF_UNIT_REQS,
  localparam int unsigned UCW   = $clog2(UNIT_REQS),
  localparam int unsigned TOTAL = 2 * UNIT_REQS
) (
  input  logic [TOTAL-1:0] req_n,
  input  logic             ein_n,
  output logic [UCW:0]     code_n,
  output logic             gs_n,
  output logic             eout_n
);
  logic [UCW-1:0] hi_code_n, lo_code_n;
  logic           hi_gs_n, lo_gs_n;
  logic           hi_eout_n, lo_eout_n;

  prio_enc_unit #(.N(UNIT_REQS)) u_hi (
    .req_n  (req_n[TOTAL-1:UNIT_REQS]),
    .ein_n  (ein_n),
    .code_n (hi_code_n),
    .gs_n   (hi_gs_n),
    .eout_n (hi_eout_n)
  );

  prio_enc_unit #(.N(UNIT_REQS)) u_lo (
    .req_n  (req_n[UNIT_REQS-1:0]),
    .ein_n  (hi_eout_n),
    .code_n (lo_code_n),
    .gs_n   (lo_gs_n),
    .eout_n (lo_eout_n)
  );

  assign code_n = {hi_gs_n, hi_code_n & lo_code_n};
  assign gs_n   = hi_gs_n & lo_gs_n;
  assign eout_n = lo_eout_n;
endmodule

// File: rtl/prio_enc_cascade_chk.sv
module prio_enc_cascade_chk #(
  parameter int unsigned UNIT_REQS = prio_enc_pkg::DEF_UNIT_REQS,
  localparam int unsigned UCW   = $clog2(UNIT_REQS),
  localparam int unsigned TOTAL = 2 * UNIT_REQS
) (
  input logic [TOTAL-1:0] req_n,
  input logic             ein_n,
  input logic [UCW:0]     code_n,
  input logic             gs_n,
  input logic             eout_n
);
  logic [UCW:0]     win;
  logic [TOTAL-1:0] above;

  assign win   = ~code_n;
  assign above = (~req_n) >> win;

  always_comb begin
    assert_disabled_quiet_R9: assert (!ein_n || (code_n == '1 && gs_n && eout_n))
      else $error("disabled cascade drives an active output");
    assert_flags_exclusive_R8: assert (gs_n || eout_n)
      else $error("group-valid and idle-pass both low");
    assert_idle_pass_R8: assert (eout_n == !(!ein_n && (&req_n)))
      else $error("idle-pass disagrees with requests");
    assert_winner_active_R6: assert (gs_n || !req_n[win])
      else $error("reported index is not an active request");
    assert_nothing_above_R7: assert (gs_n || above == TOTAL'(1))
      else $error("an active request outranks the reported one");
    assert_idle_code_R6: assert (!gs_n || code_n == '1)
      else $error("code not all ones without a winner");
  end
endmodule

bind prio_enc_cascade prio_enc_cascade_chk #(.UNIT_REQS(UNIT_REQS)) u_chk (.*);

// File: tb/prio_enc_cascade_tb.sv
module prio_enc_cascade_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [15:0] c_req_n = '1;
  logic        c_ein_n = 1'b1;
  logic [3:0]  c_code_n;
  logic        c_gs_n, c_eout_n;
  logic [7:0]  u_req_n = '1;
  logic        u_ein_n = 1'b1;
  logic [2:0]  u_code_n;
  logic        u_gs_n, u_eout_n;

  prio_enc_cascade u_dut (
    .req_n (c_req_n), .ein_n (c_ein_n),
    .code_n (c_code_n), .gs_n (c_gs_n), .eout_n (c_eout_n)
  );

  prio_enc_unit #(.N(8)) u_unit (
    .req_n (u_req_n), .ein_n (u_ein_n),
    .code_n (u_code_n), .gs_n (u_gs_n), .eout_n (u_eout_n)
  );

  typedef struct {
    logic [3:0] c_code; logic c_gs; logic c_eo;
    string c_tag_code; string c_tag_flag;
    logic [2:0] u_code; logic u_gs; logic u_eo;
    string u_tag_code; string u_tag_gs; string u_tag_eo;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   drv_done = 1'b0;

  function automatic int top_index(input logic [15:0] act, input int w);
    int r = -1;
    for (int i = 0; i < w; i++) if (act[i]) r = i;
    return r;
  endfunction

  task automatic drive(input logic [15:0] creq, input logic cein,
                       input logic [7:0] ureq, input logic uein);
    exp_t e;
    int   ci, ui;
    @(negedge clk);
    c_req_n = creq; c_ein_n = cein; u_req_n = ureq; u_ein_n = uein;
    ci = top_index(~creq, 16);
    ui = top_index({8'h00, ~ureq}, 8);
    if (cein) begin
      e.c_code = 4'hF; e.c_gs = 1; e.c_eo = 1; e.c_tag_code = "R9"; e.c_tag_flag = "R9";
    end else if (ci < 0) begin
      e.c_code = 4'hF; e.c_gs = 1; e.c_eo = 0; e.c_tag_code = "R6"; e.c_tag_flag = "R8";
    end else begin
      e.c_code = ~4'(ci); e.c_gs = 0; e.c_eo = 1;
      e.c_tag_code = (ci >= 8 && creq[7:0] != 8'hFF) ? "R7" : "R6";
      e.c_tag_flag = "R8";
    end
    if (uein) begin
      e.u_code = 3'h7; e.u_gs = 1; e.u_eo = 1;
      e.u_tag_code = "R5"; e.u_tag_gs = "R5"; e.u_tag_eo = "R5";
    end else if (ui < 0) begin
      e.u_code = 3'h7; e.u_gs = 1; e.u_eo = 0;
      e.u_tag_code = "R4"; e.u_tag_gs = "R3"; e.u_tag_eo = "R4";
    end else begin
      e.u_code = ~3'(ui); e.u_gs = 0; e.u_eo = 1;
      e.u_tag_code = ($countones(~ureq) > 1) ? "R2" : "R1";
      e.u_tag_gs = "R3"; e.u_tag_eo = "R4";
    end
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: outputs are combinational, due in the cycle they were driven
  initial begin
    forever begin
      exp_t e;
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp(e.c_tag_code, "cascade code_n", c_code_n, e.c_code);
        cmp(e.c_tag_flag, "cascade gs_n",   {3'b0, c_gs_n}, {3'b0, e.c_gs});
        cmp(e.c_tag_flag, "cascade eout_n", {3'b0, c_eout_n}, {3'b0, e.c_eo});
        cmp(e.u_tag_code, "unit code_n",    {1'b0, u_code_n}, {1'b0, e.u_code});
        cmp(e.u_tag_gs,   "unit gs_n",      {3'b0, u_gs_n}, {3'b0, e.u_gs});
        cmp(e.u_tag_eo,   "unit eout_n",    {3'b0, u_eout_n}, {3'b0, e.u_eo});
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state after reset: both disabled, R5 and R9
    drive(16'hFFFF, 1'b1, 8'hFF, 1'b1);
    // directed: requests 2 and 4 active -> index 4 (R2); 12 and 3 -> 12 (R7)
    drive(16'hEFF7, 1'b0, 8'hEB, 1'b0);
    // disabled with requests present: R5 and R9
    for (int k = 0; k < 64; k++)
      drive(16'(k * 1021), 1'b1, 8'(k * 37), 1'b1);
    // exhaustive: cascade over all 65536 patterns, unit over 256 x enable
    for (int k = 0; k < 65536; k++)
      drive(16'(k), 1'b0, 8'(k), k[8]);
    drv_done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (drv_done && q.size() == 0);
        @(posedge clk); #2;
      end
      begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule